// File: doc/BRIEF.md
# Serial Presence-Detect Memory Slave

This block is a two-wire (I2C) slave that holds a 256-byte presence-detect store describing a memory module. A host controller addresses it with a 7-bit slave address. The high four bits are a fixed device-type code and the low three bits come from board strap pins, so up to eight such modules can sit on one bus. The host can write single bytes, set the word pointer and read back from it, or stream reads from the current pointer.

The store is loaded at reset from a parameter image. Byte 63 of that image is computed as the checksum of bytes 0..62. The lower half (bytes 0..127) describes the module and can be frozen with a write-protect input. The upper half (bytes 128..255) stays writable at all times. A `checksum_ok` output continuously reports whether byte 63 still matches the sum of bytes 0..62.

The bus lines are sampled by the system clock. SDA is driven open-drain through `sda_oe`: when it is 1, the line is pulled low.

Top module: `spd_eeprom_slave`

## Requirements
- R1: While reset is held and right after it, `sda_oe` is 0 and `checksum_ok` is 1.
- R2: The slave acknowledges only an address byte whose bits 7..4 are 4'b1010 and whose bits 3..1 equal `strap[2:0]`. Bit 0 is the direction: 1 means read. Any other address gets no acknowledge, and the slave stays silent until the next START.
- R3: A write transaction is device address, then word address, then data. It stores the data byte at the word address. A later read returns that byte.
- R4: In a read, the slave sends each byte MSB first. The pointer advances after every byte and wraps from 255 to 0. A master acknowledge (SDA low) requests the next byte.
- R5: With `wp`=1, writes to addresses 0..127 are acknowledged but leave the store unchanged. Writes to 128..255 take effect regardless of `wp`.
- R6: `checksum_ok` is 1 exactly when byte 63 equals the modulo-256 sum of bytes 0..62, and it follows every write.
- R7: Several data bytes in one write transaction go to consecutive addresses, with the pointer wrapping from 255 to 0.
- R8: A STOP in the middle of a byte discards that byte and returns the slave to idle. A START in the middle of a byte discards it and begins a new address phase.
- R9: After a master no-acknowledge on read data, the slave releases SDA and drives nothing until a new START.
- R10: After reset, byte 0 is 0x80, byte 1 is 0x08, byte 63 is the checksum of bytes 0..62, and bytes 64..255 are 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset; reloads the image |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Board strap bits forming the low slave-address bits |
| wp | input | 1 | Write protect for bytes 0..127 |
| checksum_ok | output | 1 | Byte 63 equals the sum of bytes 0..62 |

## Verification
The assertions assume that SCL and SDA are held for many system clocks in each phase. They also assume that SDA changes only while SCL is low, except for deliberate START and STOP conditions, and that reset lasts at least one clock. The stimulus keeps every SCL half-period at eight clocks. It changes SDA at the falling edge of SCL and raises SCL only after SDA has settled. START and STOP are built from separate steps, each several clocks long. Because of this, the two-stage synchroniser never sees a clock edge and a data edge in the same cycle.

// File: rtl/spd_eeprom_slave.sv
`timescale 1ns/1ps
module spd_eeprom_slave #(
  parameter int ADDR_W = 8,
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter int CSUM_IDX = 63,
  parameter int PROFILE_BYTES = 16,
  parameter logic [8*PROFILE_BYTES-1:0] PROFILE = 128'h01_08_08_80_02_60_A0_01_00_48_01_09_0C_04_08_80,
  parameter logic [7:0] BLANK = 8'hFF
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       checksum_ok
);

  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [7:0] head_byte(int i);
    if (i < PROFILE_BYTES) return PROFILE[8*i +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] head_sum();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < CSUM_IDX; i++) s = s + head_byte(i);
    return s;
  endfunction

  localparam logic [7:0] INIT_SUM = head_sum();

  function automatic logic [7:0] init_byte(int i);
    if (i == CSUM_IDX) return INIT_SUM;
    if (i < CSUM_IDX) return head_byte(i);
    return BLANK;
  endfunction

  typedef enum logic [2:0] {IDLE, DEV, WORD, WDATA, RDATA, SACK, MACK} st_t;

  st_t st, nxt;
  logic [2:0] scl_s, sda_s;
  logic [7:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic nack;
  logic [7:0] sum;

  logic scl_rise, scl_fall, start_det, stop_det, addr_hit, wr_block, bit_in;
  assign bit_in    = sda_s[1];
  assign scl_rise  = scl_s[1] & ~scl_s[2];
  assign scl_fall  = ~scl_s[1] & scl_s[2];
  assign start_det = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  assign stop_det  = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  assign addr_hit  = (sh[7:1] == {DEV_TYPE, strap});
  assign wr_block  = wp & ~ptr[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s  <= 3'b111;
      sda_s  <= 3'b111;
      st     <= IDLE;
      nxt    <= IDLE;
      ptr    <= '0;
      sh     <= '0;
      cnt    <= '0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
    end else begin
      scl_s <= {scl_s[1:0], scl_in};
      sda_s <= {sda_s[1:0], sda_in};
      if (start_det) begin
        st     <= DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          DEV, WORD, WDATA: begin
            sh  <= {sh[6:0], bit_in};
            cnt <= cnt + 4'd1;
          end
          RDATA: cnt <= cnt + 4'd1;
          MACK:  nack <= bit_in;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          DEV: if (cnt == 4'd8) begin
            if (addr_hit) begin
              sda_oe <= 1'b1;
              st     <= SACK;
              nxt    <= sh[0] ? RDATA : WORD;
            end else begin
              st <= IDLE;
            end
          end
          WORD: if (cnt == 4'd8) begin
            ptr    <= sh[ADDR_W-1:0];
            sda_oe <= 1'b1;
            st     <= SACK;
            nxt    <= WDATA;
          end
          WDATA: if (cnt == 4'd8) begin
            if (!wr_block) mem[ptr] <= sh;
            ptr    <= ptr + 1'b1;
            sda_oe <= 1'b1;
            st     <= SACK;
            nxt    <= WDATA;
          end
          SACK: begin
            st  <= nxt;
            cnt <= '0;
            if (nxt == RDATA) begin
              sh     <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
          RDATA: if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            st     <= MACK;
          end else begin
            sda_oe <= ~sh[6];
            sh     <= {sh[6:0], 1'b0};
          end
          MACK: if (nack) begin
            st <= IDLE;
          end else begin
            st     <= RDATA;
            cnt    <= '0;
            sh     <= mem[ptr];
            sda_oe <= ~mem[ptr][7];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    sum = 8'h00;
    for (int i = 0; i < CSUM_IDX; i++) sum = sum + mem[i];
  end
  assign checksum_ok = (sum == mem[CSUM_IDX]);

  // R9
  oe_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == SACK || st == RDATA));

  // R2
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DEV && scl_fall && cnt == 4'd8 && sh[7:1] != {DEV_TYPE, strap}) |=> (st == IDLE && !sda_oe));

  // R5
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && !ptr[ADDR_W-1]) |=> mem[$past(ptr)] == $past(mem[ptr]));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1 || $past(st) == WORD));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == IDLE && !sda_oe));

endmodule

// File: tb/tb_spd_eeprom_slave.sv
`timescale 1ns/1ps
module tb_spd_eeprom_slave;
  localparam int HP = 8;
  localparam logic [127:0] PROF = 128'h01_08_08_80_02_60_A0_01_00_48_01_09_0C_04_08_80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0;
  logic sda_oe, cs_ok;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  spd_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap(strap), .wp(wp), .checksum_ok(cs_ok));

  logic [7:0] mref [256];
  int ptr_m = 0;
  int vectors = 0, miscomp = 0;
  logic chk_en = 1'b0, exp_oe = 1'b0;
  string req = "R1";

  function automatic logic ref_cs();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 63; i++) s = s + mref[i];
    return s == mref[63];
  endfunction

  function automatic logic [7:0] fix_byte();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 63; i++) s = s + mref[i];
    return s;
  endfunction

  task automatic chk(input string r, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (chk_en) begin
    chk(req, "sda_oe", sda_oe, exp_oe);
    chk("R6", "checksum_ok", cs_ok, ref_cs());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, input logic e);
    m_sda = b;
    idle(5);
    exp_oe = e;
    chk_en = 1'b1;
    idle(HP - 5);
    m_scl = 1'b1;
    idle(HP);
    chk_en = 1'b0;
    m_scl = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; idle(4);
    m_scl = 1'b1; idle(HP);
    m_sda = 1'b0; idle(HP);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; idle(4);
    m_scl = 1'b1; idle(HP);
    m_sda = 1'b1; idle(HP);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) clk_bit(v[i], 1'b0);
  endtask

  task automatic ack_bit(input logic e);
    clk_bit(1'b1, e);
  endtask

  task automatic recv_byte(input logic m_ack);
    logic [7:0] v;
    v = mref[ptr_m];
    for (int i = 7; i >= 0; i--) clk_bit(1'b1, ~v[i]);
    ptr_m = (ptr_m + 1) % 256;
    clk_bit(~m_ack, 1'b0);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic write_run(input int addr, input logic [7:0] first, input int n, input string r);
    req = r;
    bus_start();
    send_bits(dev(1'b0), 8); ack_bit(1'b1);
    send_bits(addr[7:0], 8); ptr_m = addr; ack_bit(1'b1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = first + k[7:0];
      send_bits(d, 8);
      if (!(wp && ptr_m < 128)) mref[ptr_m] = d;
      ptr_m = (ptr_m + 1) % 256;
      ack_bit(1'b1);
    end
    bus_stop();
  endtask

  task automatic read_run(input int addr, input int n, input string r);
    req = r;
    bus_start();
    send_bits(dev(1'b0), 8); ack_bit(1'b1);
    send_bits(addr[7:0], 8); ptr_m = addr; ack_bit(1'b1);
    bus_start();
    send_bits(dev(1'b1), 8); ack_bit(1'b1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mref[i] = (i < 16) ? PROF[8*i +: 8] : (i < 63) ? 8'h00 : 8'hFF;
    mref[63] = fix_byte();

    idle(3);
    chk("R1", "sda_oe in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    idle(3);
    chk("R1", "sda_oe after reset", sda_oe, 1'b0);
    chk("R1", "checksum_ok after reset", cs_ok, 1'b1);

    // R10 reset image
    read_run(0, 2, "R10");
    read_run(62, 3, "R10");

    // R2 foreign addresses ignored
    req = "R2";
    bus_start();
    send_bits({4'b1010, 3'b011, 1'b0}, 8); ack_bit(1'b0);
    send_bits(8'h10, 8); ack_bit(1'b0);
    bus_stop();
    bus_start();
    send_bits({4'b1011, strap, 1'b1}, 8); ack_bit(1'b0);
    clk_bit(1'b1, 1'b0); clk_bit(1'b1, 1'b0);
    bus_stop();
    strap = 3'b010;
    read_run(1, 1, "R2");
    strap = 3'b101;

    // R3 single write and readback
    write_run(150, 8'h3C, 1, "R3");
    read_run(150, 1, "R3");

    // R7 multi-byte write wrapping, then R4 sequential read wrapping
    write_run(255, 8'hA5, 2, "R7");
    read_run(254, 4, "R4");

    // R6 checksum tracking
    write_run(0, 8'h80, 1, "R6");
    write_run(5, 8'h11, 1, "R6");
    write_run(63, fix_byte(), 1, "R6");

    // R5 write protect
    wp = 1'b1;
    write_run(10, 8'h55, 1, "R5");
    write_run(200, 8'h66, 1, "R5");
    read_run(9, 3, "R5");
    read_run(200, 1, "R5");
    wp = 1'b0;

    // R8 STOP in mid-byte discards data
    req = "R8";
    bus_start();
    send_bits(dev(1'b0), 8); ack_bit(1'b1);
    send_bits(8'd150, 8); ack_bit(1'b1);
    send_bits(8'h00, 4);
    bus_stop();
    read_run(150, 1, "R8");

    // R8 START in mid-byte restarts address phase
    req = "R8";
    bus_start();
    send_bits(dev(1'b0), 8); ack_bit(1'b1);
    send_bits(8'h00, 3);
    bus_start();
    send_bits(dev(1'b1), 8); ack_bit(1'b1);
    recv_byte(1'b0);
    bus_stop();

    // R9 release after master no-acknowledge
    req = "R9";
    bus_start();
    send_bits(dev(1'b0), 8); ack_bit(1'b1);
    send_bits(8'd16, 8); ptr_m = 16; ack_bit(1'b1);
    bus_start();
    send_bits(dev(1'b1), 8); ack_bit(1'b1);
    recv_byte(1'b0);
    for (int k = 0; k < 9; k++) clk_bit(1'b0, 1'b0);
    bus_stop();

    idle(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule